// File: doc/BRIEF.md
# Input Pulse Interval Capture Timer

This block is one timer channel that measures the time between valid transitions on an external input. While it runs, an up-counter advances by one on every clock cycle in which the count-enable tick is high. When the selected transition appears on the input, the block copies the running count into a capture register, clears the counter to zero and raises a one-cycle interrupt. The captured value is therefore the length of the interval that just ended, measured in ticks.

A software start trigger begins a measurement. If the channel is already running, a start trigger acts like an input transition: it captures, restarts the count and interrupts. At every capture an overflow flag records whether the counter wrapped during the interval that just ended. A stop trigger freezes the counter and the overflow flag. The input passes through a two-flop synchronizer and, when enabled, a glitch filter that accepts a new level only after it has been stable for three samples. Prescaler selection, register access by software and output-pin control are left to the surrounding logic.

Top module: `ipi_capture_timer`

## Requirements
- R1: After reset the channel is stopped, the counter, capture register and overflow flag are zero, and no interrupt is raised.
- R2: A start trigger while stopped sets the running status and clears the counter to zero at that clock edge. An interrupt pulse one cycle long follows only if the start-interrupt mode input is 1 at that edge.
- R3: While running, the counter advances by one at each clock edge where the tick input is high and no capture happens. It wraps from 0xFFFF to 0x0000.
- R4: While running, a selected input transition copies the counter value into the capture register, clears the counter and raises a one-cycle interrupt. All three happen at one clock edge, two edges after the edge that first samples the changed input (filter off).
- R5: A start trigger while running behaves as a capture. It raises the interrupt whatever the start-interrupt mode input holds.
- R6: At each capture the overflow flag becomes 1 if the counter wrapped since the previous capture or start, and 0 otherwise. It does not change at any other time.
- R7: A stop trigger clears the running status. While stopped, the counter, capture register and overflow flag hold their values, and ticks and input transitions have no effect.
- R8: When a stop trigger coincides with a start trigger or an input transition, the stop wins: no capture, no start, and the channel ends up stopped.
- R9: The edge-select code is 2'b00 falling, 2'b01 rising, 2'b10 both, and 2'b11 falling. A change of the code while running applies from the next clock edge.
- R10: With the filter on, a new input level is passed to edge detection only once the synchronized input has held it for three consecutive samples. This adds three cycles of latency and drops pulses shorter than three cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable from the prescaler |
| tin | input | 1 | Raw timer input, asynchronous |
| filt_en | input | 1 | Glitch filter enable |
| edge_sel | input | 2 | Valid transition select |
| start | input | 1 | Start trigger pulse |
| stop | input | 1 | Stop trigger pulse |
| irq_on_start | input | 1 | Interrupt on start from stopped |
| cnt_val | output | 16 | Current counter value |
| cap_val | output | 16 | Capture register |
| ovf_flag | output | 1 | Overflow status of the last interval |
| running | output | 1 | Channel enabled status |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
Random input toggling with a partial tick rate, and random starts, stops, edge codes and filter switching, separates errors in interval length from errors in the tick gating. Directed transitions measure the input-to-interrupt latency with the filter off and on, and check that each edge code responds to its own transitions and to no others. Two-cycle glitches show whether the filter rejects short pulses. A run of more than 65536 ticks without a transition, followed by a short interval, shows whether the overflow flag is set at one capture and cleared at the next.

// File: rtl/ipi_capture_timer.sv
`timescale 1ns/1ps
module ipi_capture_timer #(
  parameter int W        = 16,
  parameter int FILT_LEN = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         tin,
  input  logic         filt_en,
  input  logic [1:0]   edge_sel,
  input  logic         start,
  input  logic         stop,
  input  logic         irq_on_start,
  output logic [W-1:0] cnt_val,
  output logic [W-1:0] cap_val,
  output logic         ovf_flag,
  output logic         running,
  output logic         irq
);

  localparam int HL = FILT_LEN - 1;
  localparam logic [W-1:0] CNT_MAX = '1;

  logic [1:0]    sync_q;
  logic [HL-1:0] hist_q;
  logic          filt_q;
  logic          prev_q;
  logic          ovf_pend_q;

  wire s2 = sync_q[1];
  wire [HL:0] win = {hist_q, s2};
  wire det  = filt_en ? filt_q : s2;
  wire rise = det & ~prev_q;
  wire fall = ~det & prev_q;

  logic hit;
  always_comb begin
    case (edge_sel)
      2'b01:   hit = rise;
      2'b10:   hit = rise | fall;
      default: hit = fall;
    endcase
  end

  wire active  = running & ~stop;
  wire cap_evt = active & (hit | start);
  wire launch  = ~running & start & ~stop;
  wire bump    = active & ~cap_evt & tick;
  wire wrap    = bump & (cnt_val == CNT_MAX);

  generate
    if (HL == 1) begin : g_hist1
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) hist_q <= '0;
        else        hist_q <= s2;
    end else begin : g_histn
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) hist_q <= '0;
        else        hist_q <= {hist_q[HL-2:0], s2};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      filt_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], tin};
      prev_q <= det;
      if (&win)       filt_q <= 1'b1;
      else if (~|win) filt_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_val    <= '0;
      cap_val    <= '0;
      ovf_flag   <= 1'b0;
      ovf_pend_q <= 1'b0;
      running    <= 1'b0;
      irq        <= 1'b0;
    end else begin
      irq <= cap_evt | (launch & irq_on_start);
      if (stop)       running <= 1'b0;
      else if (start) running <= 1'b1;
      if (cap_evt) begin
        cap_val  <= cnt_val;
        ovf_flag <= ovf_pend_q;
      end
      if (cap_evt | launch) begin
        cnt_val    <= '0;
        ovf_pend_q <= 1'b0;
      end else begin
        if (bump) cnt_val    <= cnt_val + 1'b1;
        if (wrap) ovf_pend_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/ipi_capture_timer_sva.sv
`timescale 1ns/1ps
module ipi_capture_timer_sva #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         start,
  input logic         stop,
  input logic         irq_on_start,
  input logic [W-1:0] cnt_val,
  input logic [W-1:0] cap_val,
  input logic         ovf_flag,
  input logic         running,
  input logic         irq
);

  a_r2_start_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && start && !stop && irq_on_start) |=> (irq && running && cnt_val == '0));

  a_r5_restart_captures: assert property (@(posedge clk) disable iff (!rst_n)
    (running && start && !stop) |=> (irq && running && cnt_val == '0));

  a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !start && !stop && tick) |=> (irq || cnt_val == W'($past(cnt_val) + W'(1))));

  a_r6_ovf_only_at_irq: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> $stable(ovf_flag));

  a_r7_stop_halts: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!running && !irq));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !start) |=> ($stable(cnt_val) && $stable(cap_val) && $stable(ovf_flag)));

  a_r8_stop_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && start) |=> (!running && $stable(cap_val)));

endmodule

bind ipi_capture_timer ipi_capture_timer_sva #(.W(W)) u_sva (
  .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .stop(stop),
  .irq_on_start(irq_on_start), .cnt_val(cnt_val), .cap_val(cap_val),
  .ovf_flag(ovf_flag), .running(running), .irq(irq)
);

// File: tb/ipi_capture_timer_tb.sv
`timescale 1ns/1ps
module ipi_capture_timer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, tin = 1'b0, filt_en = 1'b0;
  logic [1:0]  edge_sel = 2'b00;
  logic        start = 1'b0, stop = 1'b0, irq_on_start = 1'b0;
  logic [15:0] cnt_val, cap_val;
  logic        ovf_flag, running, irq;

  always #4 clk = ~clk;

  ipi_capture_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .tin(tin), .filt_en(filt_en),
    .edge_sel(edge_sel), .start(start), .stop(stop), .irq_on_start(irq_on_start),
    .cnt_val(cnt_val), .cap_val(cap_val), .ovf_flag(ovf_flag),
    .running(running), .irq(irq)
  );

  int total = 0, bad = 0, irq_cnt = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  logic [4:0]  h = '0;
  logic        mf = 1'b0, mprev = 1'b0, mrun = 1'b0;
  logic [31:0] acc = '0;
  logic [15:0] ecap = '0;
  logic        eovf = 1'b0, eirq = 1'b0;

  task automatic chk(input string req, input string fld, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h t=%0t", req, fld, act, exp, $time);
    end
  endtask

  function automatic logic sel_hit(input logic [1:0] sl, input logic d, input logic p);
    case (sl)
      2'b01:   return d & ~p;
      2'b10:   return d ^ p;
      default: return ~d & p;
    endcase
  endfunction

  task automatic step(input logic t, input logic tk, input logic sa, input logic sp,
                      input logic [1:0] sl, input logic md, input logic fe);
    logic det, hit, cap_e, launch;
    tin = t; tick = tk; start = sa; stop = sp; edge_sel = sl; irq_on_start = md; filt_en = fe;
    h = {h[3:0], t};
    det = fe ? mf : h[2];
    hit = sel_hit(sl, det, mprev);
    mprev = det;
    if (h[2] == h[3] && h[3] == h[4]) mf = h[2];
    cap_e  = mrun && !sp && (hit || sa);
    launch = !mrun && sa && !sp;
    eirq = cap_e || (launch && md);
    if (cap_e) begin
      ecap = acc[15:0];
      eovf = (acc > 32'hFFFF);
      acc = '0;
    end else if (launch) acc = '0;
    else if (mrun && !sp && tk) acc++;
    mrun = sp ? 1'b0 : (sa ? 1'b1 : mrun);
    @(posedge clk);
    @(negedge clk);
    chk(cur_req, "running", {31'd0, running}, {31'd0, mrun});
    chk(cur_req, "cnt_val(R3)", {16'd0, cnt_val}, {16'd0, acc[15:0]});
    chk(cur_req, "cap_val(R4)", {16'd0, cap_val}, {16'd0, ecap});
    chk(cur_req, "ovf_flag(R6)", {31'd0, ovf_flag}, {31'd0, eovf});
    chk(cur_req, "irq", {31'd0, irq}, {31'd0, eirq});
    if (irq) irq_cnt++;
  endtask

  task automatic idle(input int n, input logic t, input logic [1:0] sl, input logic fe);
    for (int i = 0; i < n; i++) step(t, 1'b1, 1'b0, 1'b0, sl, 1'b0, fe);
  endtask

  task automatic latency(input string req, input logic t, input logic [1:0] sl, input logic fe, input int exp);
    int n = 0;
    cur_req = req;
    irq_cnt = 0;
    for (int i = 1; i <= 10; i++) begin
      step(t, 1'b1, 1'b0, 1'b0, sl, 1'b0, fe);
      if (irq_cnt != 0 && n == 0) n = i;
    end
    chk(req, "edge-to-irq cycles", n, exp);
  endtask

  initial begin
    #(8 * 300000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1A2B3C));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    chk("R1", "running", {31'd0, running}, 0);
    chk("R1", "cnt_val", {16'd0, cnt_val}, 0);
    chk("R1", "cap_val", {16'd0, cap_val}, 0);
    chk("R1", "ovf_flag", {31'd0, ovf_flag}, 0);
    chk("R1", "irq", {31'd0, irq}, 0);

    cur_req = "R2";
    idle(6, 1'b0, 2'b01, 1'b0);
    step(1'b0, 1'b1, 1'b1, 1'b0, 2'b01, 1'b1, 1'b0);
    chk("R2", "irq at start mode=1", {31'd0, irq}, 1);
    idle(5, 1'b0, 2'b01, 1'b0);

    latency("R4", 1'b1, 2'b01, 1'b0, 3);
    latency("R10", 1'b0, 2'b00, 1'b1, 6);

    cur_req = "R10";
    irq_cnt = 0;
    step(1'b1, 1'b1, 1'b0, 1'b0, 2'b10, 1'b0, 1'b1);
    step(1'b1, 1'b1, 1'b0, 1'b0, 2'b10, 1'b0, 1'b1);
    idle(12, 1'b0, 2'b10, 1'b1);
    chk("R10", "irqs after 2-cycle glitch", irq_cnt, 0);

    cur_req = "R9";
    irq_cnt = 0;
    idle(6, 1'b1, 2'b11, 1'b0);
    chk("R9", "irqs on rise, code 11", irq_cnt, 0);
    latency("R9", 1'b0, 2'b11, 1'b0, 3);
    latency("R9", 1'b1, 2'b10, 1'b0, 3);
    latency("R9", 1'b0, 2'b10, 1'b0, 3);

    cur_req = "R5";
    step(1'b0, 1'b1, 1'b1, 1'b0, 2'b10, 1'b0, 1'b0);
    chk("R5", "irq on restart mode=0", {31'd0, irq}, 1);

    cur_req = "R8";
    step(1'b1, 1'b1, 1'b1, 1'b1, 2'b10, 1'b1, 1'b0);
    chk("R8", "running after start+stop", {31'd0, running}, 0);
    cur_req = "R7";
    irq_cnt = 0;
    for (int i = 0; i < 20; i++) step(i[1], 1'b1, 1'b0, 1'b0, 2'b10, 1'b0, 1'b0);
    chk("R7", "irqs while stopped", irq_cnt, 0);

    cur_req = "R8";
    step(1'b0, 1'b1, 1'b1, 1'b0, 2'b10, 1'b0, 1'b0);
    idle(6, 1'b0, 2'b10, 1'b0);
    step(1'b1, 1'b1, 1'b0, 1'b0, 2'b10, 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b0, 1'b0, 2'b10, 1'b0, 1'b0);
    irq_cnt = 0;
    step(1'b1, 1'b1, 1'b0, 1'b1, 2'b10, 1'b0, 1'b0);
    chk("R8", "irq when stop meets edge", irq_cnt, 0);

    cur_req = "R6";
    step(1'b1, 1'b1, 1'b1, 1'b0, 2'b10, 1'b0, 1'b0);
    idle(70000, 1'b1, 2'b10, 1'b0);
    latency("R6", 1'b0, 2'b10, 1'b0, 3);
    chk("R6", "ovf after long interval", {31'd0, ovf_flag}, 1);
    cur_req = "R6";
    idle(20, 1'b0, 2'b10, 1'b0);
    latency("R6", 1'b1, 2'b10, 1'b0, 3);
    chk("R6", "ovf after short interval", {31'd0, ovf_flag}, 0);

    cur_req = "R4";
    for (int i = 0; i < 20000; i++) begin
      logic t, tk, sa, sp, md, fe;
      logic [1:0] sl;
      t  = (($urandom % 8) == 0) ? ~tin : tin;
      tk = ($urandom % 4) != 0;
      sa = ($urandom % 64) == 0;
      sp = ($urandom % 160) == 0;
      sl = (($urandom % 100) == 0) ? 2'($urandom) : edge_sel;
      md = 1'($urandom);
      fe = (($urandom % 500) == 0) ? ~filt_en : filt_en;
      step(t, tk, sa, sp, sl, md, fe);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule